// File: doc/BRIEF.md
# Synchronous burst address generator

This block sits at the address front end of a pipelined synchronous SRAM. It captures a start address and then produces the four-beat burst sequence that the memory array walks through. Two address strobes, both active low, can start a burst. One comes from a processor and counts only while the primary chip enable is asserted. The other comes from a memory controller and loads unconditionally. An active-low advance input steps a 2-bit beat counter. Only the two low address bits follow the counter. The upper bits keep the value captured at load time.

A static mode input chooses the burst order. In interleaved order the low bits are the start bits XOR the beat count. In linear order they are the start bits plus the beat count, wrapping inside the aligned group of four. Every input is sampled on the rising clock edge. The current address, a registered select flag and the load and advance indications are all registered outputs, so they change right after the edge that sampled the inputs.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, `addr_out` becomes 0 and `load_o`, `adv_o` and `sel_o` become 0 after that edge.
- R2: With `ce_n`=0 and `strb_cpu_n`=0 at an edge, `addr_out` equals `addr_in` after that edge, `load_o`=1 and the beat count restarts at 0.
- R3: With `strb_ctl_n`=0 at an edge, `addr_in` is loaded whatever the value of `ce_n`, and `load_o`=1 after that edge. This includes the case where both strobes are low together.
- R4: With no load and `adv_n`=0, the beat count steps by one and `adv_o`=1. With no load and `adv_n`=1, `addr_out` is held and `adv_o`=0.
- R5: With `seq_lin`=0 (interleaved), `addr_out[1:0]` equals the start low bits XOR the beat count. A start of 01 gives 01, 00, 11, 10.
- R6: With `seq_lin`=1 (linear), `addr_out[1:0]` equals the start low bits plus the beat count, modulo 4. A start of 10 gives 10, 11, 00, 01.
- R7: A low `strb_cpu_n` while `ce_n`=1 is ignored. If `adv_n`=0 the burst advances, otherwise the address is held, and `load_o` stays 0.
- R8: Either strobe that loads takes priority over `adv_n`=0. The cycle loads and `adv_o`=0.
- R9: `addr_out[ADDR_W-1:2]` does not change between loads. After four advances the beat count wraps and the start address returns.
- R10: `sel_o` takes the value of `!ce_n` on each load and holds it until the next load.
- R11: `load_o` and `adv_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Primary chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, qualified by ce_n |
| strb_ctl_n | input | 1 | Controller address strobe, active low, unconditional |
| adv_n | input | 1 | Burst advance, active low |
| seq_lin | input | 1 | Burst order: 0 interleaved, 1 linear (static) |
| addr_in | input | ADDR_W | Start address |
| addr_out | output | ADDR_W | Current burst address (registered) |
| sel_o | output | 1 | Chip-enable state captured at the last load |
| load_o | output | 1 | Previous edge loaded a new address |
| adv_o | output | 1 | Previous edge advanced the burst |

## Verification
A wrong beat count or a wrong stored start address shows up on `addr_out` in the first cycle after the edge where it goes wrong, because the output register is fed directly from the next-state values. A corrupted upper base, or a stray load, shows as a change in the upper address bits or as a rise of `load_o` during a run of advances. An error in the load decision shows as a wrong `sel_o`, or as `load_o` and `adv_o` being 1 together. A counter that fails to wrap appears on the fifth beat as an address other than the start.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADV  = 2'd1,
    OP_LOAD = 2'd2
  } burst_op_t;

  // Low address bits for a given beat: XOR order or wrapping add order.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       lin);
    logic [1:0] r;
    if (lin) r = start + beat;
    else     r = start ^ beat;
    return r;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic      ce_n,
  input  logic      strb_cpu_n,
  input  logic      strb_ctl_n,
  input  logic      adv_n,
  output burst_op_t op
);

  logic cpu_take;
  logic ctl_take;

  assign cpu_take = !strb_cpu_n && !ce_n;
  assign ctl_take = !strb_ctl_n;

  always_comb begin
    if (cpu_take || ctl_take) op = OP_LOAD;
    else if (!adv_n)          op = OP_ADV;
    else                      op = OP_HOLD;
  end

endmodule

// File: rtl/burst_cnt.sv
module burst_cnt
  import burst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  burst_op_t        op,
  output logic [CNT_W-1:0] cnt_nxt
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    unique case (op)
      OP_LOAD: cnt_nxt = '0;
      OP_ADV:  cnt_nxt = cnt_q + 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/burst_base.sv
module burst_base
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_op_t         op,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_nxt,
  output logic              sel_nxt
);

  logic [ADDR_W-1:0] base_q;
  logic              sel_q;

  always_comb begin
    if (op == OP_LOAD) begin
      base_nxt = addr_in;
      sel_nxt  = !ce_n;
    end else begin
      base_nxt = base_q;
      sel_nxt  = sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_nxt;
      sel_q  <= sel_nxt;
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              seq_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sel_o,
  output logic              load_o,
  output logic              adv_o
);

  localparam int CNT_W = 2;

  burst_op_t         op;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [ADDR_W-1:0] base_nxt;
  logic              sel_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  burst_ctrl u_ctrl (
    .ce_n       (ce_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .op         (op)
  );

  burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .cnt_nxt (cnt_nxt)
  );

  burst_base #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ce_n     (ce_n),
    .addr_in  (addr_in),
    .base_nxt (base_nxt),
    .sel_nxt  (sel_nxt)
  );

  // Upper bits pass through from the base; low bits follow the burst order.
  assign addr_nxt = {base_nxt[ADDR_W-1:CNT_W],
                     beat_low(base_nxt[CNT_W-1:0], cnt_nxt, seq_lin)};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      sel_o    <= 1'b0;
      load_o   <= 1'b0;
      adv_o    <= 1'b0;
    end else begin
      addr_out <= addr_nxt;
      sel_o    <= sel_nxt;
      load_o   <= (op == OP_LOAD);
      adv_o    <= (op == OP_ADV);
    end
  end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              adv_n,
  input logic              seq_lin,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              sel_o,
  input logic              load_o,
  input logic              adv_o
);

  // R2 and R3: a qualified strobe captures the input address
  a_r3_strobe_loads: assert property (@(posedge clk) disable iff (rst)
    (!strb_ctl_n || (!strb_cpu_n && !ce_n)) |=>
      (load_o && !adv_o && addr_out == $past(addr_in) && sel_o == !$past(ce_n)));

  // R7: processor strobe without chip enable does not load
  a_r7_cpu_ignored: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && ce_n && strb_ctl_n) |=> !load_o);

  // R4: hold keeps the address while the mode is unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (strb_ctl_n && (strb_cpu_n || ce_n) && adv_n) |=>
      ((seq_lin != $past(seq_lin)) || $stable(addr_out)));

  // R9: upper bits stay fixed between loads
  a_r9_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (strb_ctl_n && (strb_cpu_n || ce_n)) |=>
      (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

  // R10: select flag only changes on a load
  a_r10_sel_held: assert property (@(posedge clk) disable iff (rst)
    (strb_ctl_n && (strb_cpu_n || ce_n)) |=> $stable(sel_o));

  // R11: load and advance indications are exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_o, adv_o}));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce_n       (ce_n),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .adv_n      (adv_n),
  .seq_lin    (seq_lin),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .sel_o      (sel_o),
  .load_o     (load_o),
  .adv_o      (adv_o)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

  localparam int AW = 20;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1, seq_lin = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          sel_o, load_o, adv_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .seq_lin(seq_lin),
    .addr_in(addr_in), .addr_out(addr_out), .sel_o(sel_o),
    .load_o(load_o), .adv_o(adv_o)
  );

  // {ce_n, cpu_n, ctl_n, adv_n, lin, addr_in, exp_addr, exp_load, exp_adv, exp_sel}
  localparam logic [47:0] VEC [NV] = '{
    {5'b00110, 20'h12345, 20'h12345, 3'b101},
    {5'b01100, 20'h00000, 20'h12344, 3'b011},
    {5'b01100, 20'h00000, 20'h12347, 3'b011},
    {5'b01100, 20'h00000, 20'h12346, 3'b011},
    {5'b01110, 20'h00000, 20'h12346, 3'b001},
    {5'b01100, 20'h00000, 20'h12345, 3'b011},
    {5'b11011, 20'h0ABC6, 20'h0ABC6, 3'b100},
    {5'b11101, 20'h00000, 20'h0ABC7, 3'b010},
    {5'b11101, 20'h00000, 20'h0ABC4, 3'b010},
    {5'b11101, 20'h00000, 20'h0ABC5, 3'b010},
    {5'b10101, 20'h7FFFF, 20'h0ABC6, 3'b010},
    {5'b00101, 20'hFFFFF, 20'hFFFFF, 3'b101},
    {5'b01101, 20'h00000, 20'hFFFFC, 3'b011},
    {5'b11001, 20'h00003, 20'h00003, 3'b100},
    {5'b11111, 20'h00000, 20'h00003, 3'b000}
  };

  string TAG [NV] = '{"R2", "R5", "R5", "R5", "R4", "R9", "R3", "R6",
                      "R6", "R6", "R7", "R8", "R9", "R8", "R10"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] ctl, input logic [AW-1:0] a);
    @(negedge clk);
    {ce_n, strb_cpu_n, strb_ctl_n, adv_n, seq_lin} = ctl;
    addr_in = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    step(5'b01100, 20'h55555);
    step(5'b00000, 20'h55555);
    chk("R1", {12'd0, addr_out}, 32'd0);
    chk("R1", {29'd0, load_o, adv_o, sel_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][47:43], VEC[i][42:23]);
      chk(TAG[i], {12'd0, addr_out}, {12'd0, VEC[i][22:3]});
      chk(TAG[i], {29'd0, load_o, adv_o, sel_o}, {29'd0, VEC[i][2:0]});
      chk("R11", {31'd0, load_o & adv_o}, 32'd0);
    end

    // R3: both strobes with chip enable off still load via the controller strobe
    step(5'b10000, 20'h2468B);
    chk("R3", {12'd0, addr_out}, 32'h2468B);
    chk("R3", {29'd0, load_o, adv_o, sel_o}, 32'b100);

    // R5: interleaved from start 11 gives 11, 10, 01, 00 then wraps (R9)
    step(5'b11010, 20'h3000F);
    chk("R5", {12'd0, addr_out}, 32'h3000F);
    step(5'b11100, 20'h0);
    chk("R5", {12'd0, addr_out}, 32'h3000E);
    step(5'b11100, 20'h0);
    chk("R5", {12'd0, addr_out}, 32'h3000D);
    step(5'b11100, 20'h0);
    chk("R5", {12'd0, addr_out}, 32'h3000C);
    step(5'b11100, 20'h0);
    chk("R9", {12'd0, addr_out}, 32'h3000F);

    // R1: reset in mid-burst clears everything
    @(negedge clk);
    rst = 1'b1;
    {ce_n, strb_cpu_n, strb_ctl_n, adv_n} = 4'b0100;
    @(posedge clk);
    #1;
    chk("R1", {12'd0, addr_out}, 32'd0);
    chk("R1", {29'd0, load_o, adv_o, sel_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule